// File: doc/BRIEF.md
# Set-Associative Cache with Run-Time Write Policy

This block sits between a processor that issues single-byte loads and stores and a slower block-wide backing memory. It keeps 2^SET_BITS sets of WAYS lines, each line carrying a valid flag, a dirty flag, a tag and a block of 2^OFF_BITS bytes. A request address is cut, from the top down, into tag, set index and byte offset. A lookup compares the tag against every valid line of the indexed set. A hit is answered in the cycle it is presented. A miss fetches the whole block from memory into the set, replacing an empty way or else the least recently used one, and then the request completes as a hit.

The `wb_mode` input picks the write policy for each request. When it is high, write hits stay in the cache and mark the line dirty, write misses allocate, and a dirty victim is copied back as a full block before the refill. When it is low, every store goes straight to memory as a single-byte write, updates the cached copy if one is present, and never allocates. Two counters report the completed requests and how many of them missed.

Top module: `sa_cache`

## Requirements
- R1: A request hits when a valid line of set `cpu_addr[OFF_BITS+SET_BITS-1:OFF_BITS]` holds tag `cpu_addr[ADDR_W-1:OFF_BITS+SET_BITS]`. A hit raises `cpu_ready` in the same cycle, and `cpu_rdata` returns byte `cpu_addr[OFF_BITS-1:0]` of the block.
- R2: After reset every line is invalid, both counters are zero, and with no request `cpu_ready` and `mem_req` are low.
- R3: A read miss issues one memory read (`mem_we`=0) at the block base address (offset bits zero), places the returned block in the set, and then completes with the requested byte.
- R4: The way filled on a miss is the lowest-numbered invalid way of the set. If every way is valid, it is the least recently used way. Recency is updated on every hit and on every fill.
- R5: In write-back mode (`wb_mode`=1), a write hit changes only the cached byte, completes in the request cycle, and produces no memory traffic.
- R6: In write-back mode, a write miss allocates the block by a refill and then writes the byte into the cache only.
- R7: A victim that is valid and dirty is written to memory as one full-block write (`mem_be` all ones) at its own block address before the refill. A clean victim causes no write.
- R8: In write-through mode (`wb_mode`=0), every write issues exactly one memory write with only `mem_be[offset]` set. A write hit also updates the cached byte. A write miss does not allocate a line.
- R9: `cpu_ready` stays low from a miss until the refill is done. With a one-cycle memory acknowledge, a clean miss completes 3 cycles after it is presented, a dirty-victim miss after 5 cycles, and a write-through write after 3 cycles.
- R10: `access_count` rises by one for each completed request. `miss_count` rises by one for each completed request whose lookup missed, including a write-through write miss.
- R11: With 4-bit addresses and 2-byte blocks, the read sequence 0,1,7,8,0 gives miss,hit,miss,miss,miss with 4 sets of 1 way, and miss,hit,miss,miss,hit with 2 sets of 2 ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wb_mode | input | 1 | 1 = write-back with allocate, 0 = write-through without allocate |
| cpu_valid | input | 1 | Request present; held with its fields until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 8 | Load byte, valid with `cpu_ready` |
| mem_req | output | 1 | Memory transfer pending, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = block read |
| mem_addr | output | ADDR_W | Block base byte address |
| mem_be | output | 2^OFF_BITS | Byte enables of a write |
| mem_wdata | output | 8*2^OFF_BITS | Write block, byte i in bits [8i+7:8i] |
| mem_ack | input | 1 | Transfer done; read data valid |
| mem_rdata | input | 8*2^OFF_BITS | Read block |
| access_count | output | CNT_W | Completed requests |
| miss_count | output | CNT_W | Completed requests that missed |

## Verification
Short directed sequences within one set separate the replacement choices: a reuse before a conflicting fill must save the reused line and evict the other. Mixed load and store sequences in both modes tell deferred updates from immediate ones. The backing memory is inspected right after a store and again after the eviction. Stall lengths tell clean misses from dirty ones. Two small instances replay the same five-read sequence, where only associativity separates the last result. A long random run of loads, stores and mode flips over a small address window forces frequent conflicts, and every loaded byte is compared with an ideal flat memory.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVICT = 3'd1,
    ST_FILL  = 3'd2,
    ST_THRU  = 3'd3,
    ST_DONE  = 3'd4
  } cache_state_e;
endpackage

// File: rtl/sa_cache_lines.sv
module sa_cache_lines #(
  parameter int SETS     = 4,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 2,
  parameter int WAY_W    = 1,
  parameter int TAG_W    = 4,
  parameter int OFF_BITS = 2,
  parameter int BLK_W    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [SET_BITS-1:0]             set_i,
  input  logic                            fill_en,
  input  logic [WAY_W-1:0]                fill_way,
  input  logic [TAG_W-1:0]                fill_tag,
  input  logic [BLK_W-1:0]                fill_data,
  input  logic                            wr_en,
  input  logic [WAY_W-1:0]                wr_way,
  input  logic [OFF_BITS-1:0]             wr_off,
  input  logic [7:0]                      wr_byte,
  input  logic                            wr_dirty,
  output logic [WAYS-1:0]                 valid_o,
  output logic [WAYS-1:0]                 dirty_o,
  output logic [WAYS-1:0][TAG_W-1:0]      tag_o,
  output logic [WAYS-1:0][BLK_W-1:0]      data_o
);
  logic [SETS-1:0][WAYS-1:0] valid_q, valid_d;
  logic [SETS-1:0][WAYS-1:0] dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [BLK_W-1:0] data_q [SETS][WAYS];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (fill_en) begin
      valid_d[set_i][fill_way] = 1'b1;
      dirty_d[set_i][fill_way] = 1'b0;
    end else if (wr_en && wr_dirty) begin
      dirty_d[set_i][wr_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[set_i][fill_way]  <= fill_tag;
      data_q[set_i][fill_way] <= fill_data;
    end else if (wr_en) begin
      data_q[set_i][wr_way][{wr_off, 3'b000} +: 8] <= wr_byte;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign valid_o[w] = valid_q[set_i][w];
    assign dirty_o[w] = dirty_q[set_i][w];
    assign tag_o[w]   = tag_q[set_i][w];
    assign data_o[w]  = data_q[set_i][w];
  end

  // byte stores only ever land in a resident line
  assert_store_resident_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> valid_q[set_i][wr_way]);
endmodule

// File: rtl/sa_cache_match.sv
module sa_cache_match #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1,
  parameter int TAG_W = 4
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           req_tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_i[w] && (tag_i[w] == req_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/sa_cache_lru.sv
module sa_cache_lru #(
  parameter int SETS     = 4,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 2,
  parameter int WAY_W    = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] set_i,
  input  logic                touch_en,
  input  logic [WAY_W-1:0]    touch_way,
  output logic [WAY_W-1:0]    victim_way
);
  // per-line age rank: 0 = most recent, WAYS-1 = least recent
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q, age_d;
  logic [WAYS-1:0] oldest_vec;

  always_comb begin
    age_d = age_q;
    if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way) begin
          age_d[set_i][w] = '0;
        end else if (age_q[set_i][w] < age_q[set_i][touch_way]) begin
          age_d[set_i][w] = WAY_W'(age_q[set_i][w] + 1'b1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else begin
      age_q <= age_d;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign oldest_vec[w] = (age_q[set_i][w] == WAY_W'(WAYS - 1));
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (oldest_vec[w]) victim_way = WAY_W'(w);
    end
  end

  // ranks stay a permutation, so exactly one way is the oldest
  assert_single_oldest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/sa_cache.sv
module sa_cache
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 2,
  parameter int OFF_BITS = 2,
  parameter int CNT_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wb_mode,
  input  logic                          cpu_valid,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [7:0]                    cpu_wdata,
  output logic                          cpu_ready,
  output logic [7:0]                    cpu_rdata,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [(1<<OFF_BITS)-1:0]      mem_be,
  output logic [8*(1<<OFF_BITS)-1:0]    mem_wdata,
  input  logic                          mem_ack,
  input  logic [8*(1<<OFF_BITS)-1:0]    mem_rdata,
  output logic [CNT_W-1:0]              access_count,
  output logic [CNT_W-1:0]              miss_count
);
  localparam int SETS      = 1 << SET_BITS;
  localparam int BLK_BYTES = 1 << OFF_BITS;
  localparam int BLK_W     = 8 * BLK_BYTES;
  localparam int TAG_W     = ADDR_W - SET_BITS - OFF_BITS;
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic [TAG_W-1:0]    req_tag;
  logic [SET_BITS-1:0] req_set;
  logic [OFF_BITS-1:0] req_off;
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_set = cpu_addr[OFF_BITS +: SET_BITS];
  assign req_off = cpu_addr[OFF_BITS-1:0];

  logic [WAYS-1:0]             rd_valid, rd_dirty, hit_vec;
  logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
  logic [WAYS-1:0][BLK_W-1:0]  rd_data;
  logic                        hit;
  logic [WAY_W-1:0]            hit_way, lru_way, vict_sel;
  logic                        fill_en, wr_en, wr_dirty, touch_en;
  logic [WAY_W-1:0]            touch_way;

  cache_state_e      state_q, state_d;
  logic [WAY_W-1:0]  vict_q, vict_d;
  logic              miss_q, miss_d;
  logic [CNT_W-1:0]  acc_q, acc_d, mcnt_q, mcnt_d;

  sa_cache_lines #(
    .SETS(SETS), .SET_BITS(SET_BITS), .WAYS(WAYS), .WAY_W(WAY_W),
    .TAG_W(TAG_W), .OFF_BITS(OFF_BITS), .BLK_W(BLK_W)
  ) u_lines (
    .clk(clk), .rst_n(rst_core_n), .set_i(req_set),
    .fill_en(fill_en), .fill_way(vict_q), .fill_tag(req_tag), .fill_data(mem_rdata),
    .wr_en(wr_en), .wr_way(hit_way), .wr_off(req_off), .wr_byte(cpu_wdata),
    .wr_dirty(wr_dirty),
    .valid_o(rd_valid), .dirty_o(rd_dirty), .tag_o(rd_tag), .data_o(rd_data)
  );

  sa_cache_match #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_match (
    .valid_i(rd_valid), .tag_i(rd_tag), .req_tag(req_tag),
    .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way)
  );

  sa_cache_lru #(.SETS(SETS), .SET_BITS(SET_BITS), .WAYS(WAYS), .WAY_W(WAY_W)) u_lru (
    .clk(clk), .rst_n(rst_core_n), .set_i(req_set),
    .touch_en(touch_en), .touch_way(touch_way), .victim_way(lru_way)
  );

  // empty way first (lowest index), otherwise the least recent one
  always_comb begin
    logic found;
    found    = 1'b0;
    vict_sel = lru_way;
    for (int w = 0; w < WAYS; w++) begin
      if (!rd_valid[w] && !found) begin
        vict_sel = WAY_W'(w);
        found    = 1'b1;
      end
    end
  end

  assign cpu_rdata = rd_data[hit_way][{req_off, 3'b000} +: 8];

  always_comb begin
    state_d   = state_q;
    vict_d    = vict_q;
    miss_d    = miss_q;
    cpu_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_be    = '0;
    mem_addr  = {req_tag, req_set, {OFF_BITS{1'b0}}};
    mem_wdata = rd_data[vict_q];
    fill_en   = 1'b0;
    wr_en     = 1'b0;
    wr_dirty  = 1'b0;
    touch_en  = 1'b0;
    touch_way = hit_way;
    case (state_q)
      ST_IDLE: begin
        if (cpu_valid) begin
          if (cpu_we && !wb_mode) begin
            wr_en    = hit;
            touch_en = hit;
            miss_d   = !hit;
            state_d  = ST_THRU;
          end else if (hit) begin
            cpu_ready = 1'b1;
            wr_en     = cpu_we;
            wr_dirty  = 1'b1;
            touch_en  = 1'b1;
            miss_d    = 1'b0;
          end else begin
            miss_d  = 1'b1;
            vict_d  = vict_sel;
            state_d = (rd_valid[vict_sel] && rd_dirty[vict_sel]) ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_be   = '1;
        mem_addr = {rd_tag[vict_q], req_set, {OFF_BITS{1'b0}}};
        if (mem_ack) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          fill_en   = 1'b1;
          touch_en  = 1'b1;
          touch_way = vict_q;
          state_d   = ST_IDLE;
        end
      end
      ST_THRU: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = BLK_BYTES'(1) << req_off;
        mem_wdata = {BLK_BYTES{cpu_wdata}};
        if (mem_ack) state_d = ST_DONE;
      end
      ST_DONE: begin
        cpu_ready = 1'b1;
        miss_d    = 1'b0;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    acc_d  = acc_q;
    mcnt_d = mcnt_q;
    if (cpu_ready) begin
      acc_d = CNT_W'(acc_q + 1'b1);
      if (miss_q) mcnt_d = CNT_W'(mcnt_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      vict_q  <= '0;
      miss_q  <= 1'b0;
      acc_q   <= '0;
      mcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      vict_q  <= vict_d;
      miss_q  <= miss_d;
      acc_q   <= acc_d;
      mcnt_q  <= mcnt_d;
    end
  end

  assign access_count = acc_q;
  assign miss_count   = mcnt_q;

  assert_one_match_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    cpu_valid |-> $onehot0(hit_vec));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_thru_single_byte_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mem_req && mem_we && state_q == ST_THRU) |-> ($countones(mem_be) == 1));

  assert_stall_during_mem_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_req |-> !cpu_ready);

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    1'b1 |=> (access_count == $past(access_count)) ||
             (access_count == CNT_W'($past(access_count) + 1'b1)));

  assert_miss_bound_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    miss_count <= access_count);
endmodule

// File: tb/sa_cache_test.sv
module sa_cache_memsim #(
  parameter int ADDR_W   = 8,
  parameter int OFF_BITS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [(1<<OFF_BITS)-1:0]    be,
  input  logic [8*(1<<OFF_BITS)-1:0]  wdata,
  output logic                        ack,
  output logic [8*(1<<OFF_BITS)-1:0]  rdata
);
  localparam int NB = 1 << OFF_BITS;
  logic [7:0] m [1<<ADDR_W];
  int rd_cnt;
  int wr_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << ADDR_W); i++) m[i] = 8'(i * 37 + 5);
      ack    <= 1'b0;
      rdata  <= '0;
      rd_cnt = 0;
      wr_cnt = 0;
    end else if (req && !ack) begin
      ack <= 1'b1;
      if (we) begin
        wr_cnt++;
        for (int b = 0; b < NB; b++) if (be[b]) m[int'(addr) + b] = wdata[8*b +: 8];
      end else begin
        rd_cnt++;
        for (int b = 0; b < NB; b++) rdata[8*b +: 8] <= m[int'(addr) + b];
      end
    end else begin
      ack <= 1'b0;
    end
  end
endmodule

module sa_cache_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  int   n_checks = 0;
  int   n_fails  = 0;
  int   cyc      = 0;

  // main instance
  logic        mode, c_valid, c_we, c_ready;
  logic [7:0]  c_addr, c_wdata, c_rdata;
  logic        m_req, m_we, m_ack;
  logic [7:0]  m_addr;
  logic [3:0]  m_be;
  logic [31:0] m_wdata, m_rdata;
  logic [15:0] acc, mis;

  sa_cache uut (
    .clk(clk), .rst_n(rst_n), .wb_mode(mode),
    .cpu_valid(c_valid), .cpu_we(c_we), .cpu_addr(c_addr), .cpu_wdata(c_wdata),
    .cpu_ready(c_ready), .cpu_rdata(c_rdata),
    .mem_req(m_req), .mem_we(m_we), .mem_addr(m_addr), .mem_be(m_be),
    .mem_wdata(m_wdata), .mem_ack(m_ack), .mem_rdata(m_rdata),
    .access_count(acc), .miss_count(mis)
  );
  sa_cache_memsim #(.ADDR_W(8), .OFF_BITS(2)) uut_mem (
    .clk(clk), .rst_n(rst_n), .req(m_req), .we(m_we), .addr(m_addr), .be(m_be),
    .wdata(m_wdata), .ack(m_ack), .rdata(m_rdata)
  );

  // two small instances for the five-read sequence
  logic       t_valid, t_sel;
  logic [3:0] t_addr;
  logic       dm_rdy, sa_rdy, dm_req, sa_req, dm_mwe, sa_mwe, dm_ack, sa_ack;
  logic [7:0] dm_rd, sa_rd;
  logic [3:0] dm_ma, sa_ma;
  logic [1:0] dm_be, sa_be;
  logic [15:0] dm_mw, sa_mw, dm_mr, sa_mr;
  logic [15:0] dm_acc, dm_mis, sa_acc, sa_mis;

  sa_cache #(.ADDR_W(4), .SET_BITS(2), .WAYS(1), .OFF_BITS(1)) dut_dm (
    .clk(clk), .rst_n(rst_n), .wb_mode(1'b1),
    .cpu_valid(t_valid && !t_sel), .cpu_we(1'b0), .cpu_addr(t_addr), .cpu_wdata(8'h00),
    .cpu_ready(dm_rdy), .cpu_rdata(dm_rd),
    .mem_req(dm_req), .mem_we(dm_mwe), .mem_addr(dm_ma), .mem_be(dm_be),
    .mem_wdata(dm_mw), .mem_ack(dm_ack), .mem_rdata(dm_mr),
    .access_count(dm_acc), .miss_count(dm_mis)
  );
  sa_cache_memsim #(.ADDR_W(4), .OFF_BITS(1)) dm_mem (
    .clk(clk), .rst_n(rst_n), .req(dm_req), .we(dm_mwe), .addr(dm_ma), .be(dm_be),
    .wdata(dm_mw), .ack(dm_ack), .rdata(dm_mr)
  );
  sa_cache #(.ADDR_W(4), .SET_BITS(1), .WAYS(2), .OFF_BITS(1)) dut_sa (
    .clk(clk), .rst_n(rst_n), .wb_mode(1'b1),
    .cpu_valid(t_valid && t_sel), .cpu_we(1'b0), .cpu_addr(t_addr), .cpu_wdata(8'h00),
    .cpu_ready(sa_rdy), .cpu_rdata(sa_rd),
    .mem_req(sa_req), .mem_we(sa_mwe), .mem_addr(sa_ma), .mem_be(sa_be),
    .mem_wdata(sa_mw), .mem_ack(sa_ack), .mem_rdata(sa_mr),
    .access_count(sa_acc), .miss_count(sa_mis)
  );
  sa_cache_memsim #(.ADDR_W(4), .OFF_BITS(1)) sa_mem (
    .clk(clk), .rst_n(rst_n), .req(sa_req), .we(sa_mwe), .addr(sa_ma), .be(sa_be),
    .wdata(sa_mw), .ack(sa_ack), .rdata(sa_mr)
  );

  logic [7:0] ref_mem [256];

  function automatic logic [7:0] init_byte(input int a);
    return 8'(a * 37 + 5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    c_valid = 1'b0;
    t_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 256; i++) ref_mem[i] = init_byte(i);
  endtask

  task automatic do_access(input logic we, input logic [7:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output int waits);
    @(negedge clk);
    c_valid = 1'b1; c_we = we; c_addr = a; c_wdata = d;
    waits = 0;
    #1;
    while (!c_ready && waits < 60) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = c_rdata;
    @(negedge clk);
    c_valid = 1'b0;
    if (we) ref_mem[a] = d;
  endtask

  task automatic t_access(input logic sel, input logic [3:0] a, output bit hit);
    int w;
    @(negedge clk);
    t_sel = sel; t_addr = a; t_valid = 1'b1;
    #1;
    hit = t_sel ? sa_rdy : dm_rdy;
    w = 0;
    while (!(t_sel ? sa_rdy : dm_rdy) && w < 60) begin
      @(negedge clk);
      #1;
      w++;
    end
    @(negedge clk);
    t_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int w, r0, w0, a0, m0;
    bit h;
    bit dm_exp [5] = '{0, 1, 0, 0, 0};
    bit sa_exp [5] = '{0, 1, 0, 0, 1};
    logic [3:0] trace [5] = '{4'd0, 4'd1, 4'd7, 4'd8, 4'd0};

    rst_n = 1'b0; mode = 1'b1; c_valid = 1'b0; c_we = 1'b0; c_addr = '0; c_wdata = '0;
    t_valid = 1'b0; t_sel = 1'b0; t_addr = '0;
    void'($urandom(32'd2024));
    do_reset();

    // R2: reset state
    #1;
    check(c_ready == 1'b0, "R2 ready after reset", c_ready, 0);
    check(m_req == 1'b0, "R2 mem_req after reset", m_req, 0);
    check(acc == 0 && mis == 0, "R2 counters zero", acc + mis, 0);

    // R3 / R9: cold read miss, R1: hit in the same block
    r0 = uut_mem.rd_cnt;
    do_access(1'b0, 8'h10, 8'h00, rd, w);
    check(rd == init_byte(8'h10), "R3 cold read data", rd, init_byte(8'h10));
    check(w == 3, "R9 clean miss stall", w, 3);
    check(uut_mem.rd_cnt - r0 == 1, "R3 one block read", uut_mem.rd_cnt - r0, 1);
    do_access(1'b0, 8'h13, 8'h00, rd, w);
    check(w == 0, "R1 hit same cycle", w, 0);
    check(rd == init_byte(8'h13), "R1 hit offset byte", rd, init_byte(8'h13));

    // R4: replacement order within set 0
    do_reset();
    do_access(1'b0, 8'h00, 0, rd, w);
    do_access(1'b0, 8'h20, 0, rd, w);
    check(w == 3, "R4 second way filled empty", w, 3);
    do_access(1'b0, 8'h00, 0, rd, w);
    check(w == 0, "R4 first line still resident", w, 0);
    do_access(1'b0, 8'h40, 0, rd, w);
    do_access(1'b0, 8'h00, 0, rd, w);
    check(w == 0, "R4 recent line survives", w, 0);
    do_access(1'b0, 8'h20, 0, rd, w);
    check(w == 3, "R4 least recent line evicted", w, 3);

    // R5 / R7 / R6: write-back
    do_reset();
    mode = 1'b1;
    do_access(1'b0, 8'h40, 0, rd, w);
    w0 = uut_mem.wr_cnt;
    do_access(1'b1, 8'h41, 8'hAB, rd, w);
    check(w == 0, "R5 write hit no stall", w, 0);
    check(uut_mem.wr_cnt == w0, "R5 no memory write", uut_mem.wr_cnt - w0, 0);
    check(uut_mem.m[8'h41] == init_byte(8'h41), "R5 memory untouched", uut_mem.m[8'h41], init_byte(8'h41));
    do_access(1'b0, 8'h41, 0, rd, w);
    check(rd == 8'hAB, "R5 cached byte updated", rd, 8'hAB);
    do_access(1'b0, 8'h00, 0, rd, w);
    w0 = uut_mem.wr_cnt;
    do_access(1'b0, 8'h80, 0, rd, w);
    check(w == 5, "R9 dirty miss stall", w, 5);
    check(uut_mem.wr_cnt - w0 == 1, "R7 one victim write", uut_mem.wr_cnt - w0, 1);
    check(uut_mem.m[8'h41] == 8'hAB, "R7 victim byte written", uut_mem.m[8'h41], 8'hAB);
    check(uut_mem.m[8'h43] == init_byte(8'h43), "R7 full block kept", uut_mem.m[8'h43], init_byte(8'h43));
    w0 = uut_mem.wr_cnt;
    do_access(1'b0, 8'hC0, 0, rd, w);
    check(uut_mem.wr_cnt == w0, "R7 clean victim no write", uut_mem.wr_cnt - w0, 0);
    check(w == 3, "R7 clean victim stall", w, 3);
    do_access(1'b1, 8'h24, 8'h5C, rd, w);
    check(w == 3, "R6 write miss allocates", w, 3);
    check(uut_mem.m[8'h24] == init_byte(8'h24), "R6 memory deferred", uut_mem.m[8'h24], init_byte(8'h24));
    do_access(1'b0, 8'h24, 0, rd, w);
    check(w == 0 && rd == 8'h5C, "R6 allocated line hit", rd, 8'h5C);

    // R8 / R10: write-through
    do_reset();
    mode = 1'b0;
    r0 = uut_mem.rd_cnt; w0 = uut_mem.wr_cnt;
    do_access(1'b1, 8'h30, 8'h11, rd, w);
    check(w == 3, "R9 write-through stall", w, 3);
    check(uut_mem.wr_cnt - w0 == 1 && uut_mem.rd_cnt == r0, "R8 single write no fill",
          uut_mem.rd_cnt - r0, 0);
    check(uut_mem.m[8'h30] == 8'h11, "R8 memory updated", uut_mem.m[8'h30], 8'h11);
    check(uut_mem.m[8'h31] == init_byte(8'h31), "R8 neighbour byte kept", uut_mem.m[8'h31], init_byte(8'h31));
    do_access(1'b0, 8'h30, 0, rd, w);
    check(w == 3, "R8 write miss not allocated", w, 3);
    check(rd == 8'h11, "R8 read after write", rd, 8'h11);
    do_access(1'b1, 8'h31, 8'h22, rd, w);
    check(uut_mem.m[8'h31] == 8'h22, "R8 write hit to memory", uut_mem.m[8'h31], 8'h22);
    do_access(1'b0, 8'h31, 0, rd, w);
    check(w == 0 && rd == 8'h22, "R8 write hit updates cache", rd, 8'h22);
    #1;
    check(acc == 4, "R10 access count", acc, 4);
    check(mis == 2, "R10 miss count", mis, 2);

    // R11: five-read sequence on both small configurations
    for (int i = 0; i < 5; i++) begin
      t_access(1'b0, trace[i], h);
      check(h == dm_exp[i], "R11 direct-mapped trace", h, dm_exp[i]);
    end
    for (int i = 0; i < 5; i++) begin
      t_access(1'b1, trace[i], h);
      check(h == sa_exp[i], "R11 two-way trace", h, sa_exp[i]);
    end
    #1;
    check(dm_mis == 4 && dm_acc == 5, "R11 direct-mapped counters", dm_mis, 4);
    check(sa_mis == 3 && sa_acc == 5, "R11 two-way counters", sa_mis, 3);

    // random mix of loads, stores and modes against a flat memory (R1 R3 R5 R8)
    do_reset();
    a0 = acc; m0 = mis;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, d;
      logic we;
      a = 8'($urandom % 64);
      d = 8'($urandom);
      we = ($urandom % 3) == 0;
      mode = 1'($urandom % 2);
      if (we) begin
        do_access(1'b1, a, d, rd, w);
      end else begin
        do_access(1'b0, a, 0, rd, w);
        check(rd == ref_mem[a], "R3 random read data", rd, ref_mem[a]);
      end
    end
    #1;
    check(acc - a0 == 400, "R10 random access count", acc - a0, 400);
    check(mis <= acc, "R10 misses bounded", mis, acc);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule